// File: doc/BRIEF.md
# Multi-rail power-good monitor

This block decides whether four regulated supply rails are healthy. It does not use analog comparators. It works on digitised feedback codes. The four rails are a core rail with a programmable reference, a fixed bus-termination rail, and two fixed auxiliary rails. Every code is a 10-bit unsigned value at 4 mV per LSB. Each comparison has hysteresis. Each comparison state is a registered bit that changes only when a sample-valid strobe is high, so a rail is assumed to have settled between samples.

The block drives two good flags and one overvoltage flag:

- **Bus-rail good flag.** It follows a short sequence. The bus rail must be out of undervoltage. The core soft-start level code must have passed the oscillator valley. The flag then rises on the next PWM pulse after those conditions are registered.
- **System power-good flag.** It is high only while the core feedback is inside its window and none of the other three rails is in undervoltage.
- **Overvoltage flag.** It marks a core feedback above about 120% of the reference, for use by a separate fault manager.

All thresholds that scale with the reference are formed by shifts and adds. The block contains no multipliers.

Top module: `railGoodMonitor`

## Requirements
- R1: Core upper limit, with r the reference code and `>>` a floor shift. The upper flag sets when the sampled core code is strictly greater than r + (r>>4) + (r>>5), about 109.4%. It clears when the code is strictly less than r + (r>>4) + (r>>7), about 107.0%. The flag is clear after reset, and it can never be set together with the lower flag.
- R2: Core lower limit. The lower flag sets when the core code is strictly less than r - (r>>4) - (r>>5), about 90.6%. It clears when the code is strictly greater than r - (r>>4) - (r>>7), about 93.0%. The flag is set after reset.
- R3: Undervoltage on the two scaled auxiliary rails, with nominal codes N = 375 and N = 450. Let rise = N - (N>>2). Undervoltage clears when the code is strictly greater than rise. It sets when the code is strictly less than rise - (N>>4) - (N>>7). This gives rise/fall codes of 282/257 and 338/307. Undervoltage is set after reset.
- R4: Undervoltage on the bus rail. It clears when the code is strictly greater than 270 (1.08 V). It sets when the code is strictly less than 258 (48 mV lower). It is set after reset.
- R5: The bus-rail good flag falls one cycle after a sample registers either bus undervoltage or a soft-start level code below 312 (1.25 V). It stays low while either condition is registered.
- R6: The bus-rail good flag rises only on a cycle whose `pwmPulse` is high and for which the following holds. At the previous clock, bus undervoltage was already clear and the soft-start level was already registered at or above the valley. A pulse that comes earlier is ignored.
- R7: The overvoltage flag holds the result of the last captured comparison: core code strictly greater than r + (r>>3) + (r>>4) + (r>>6), about 120.3%.
- R8: The system power-good flag is high exactly when the core upper flag is clear, the core lower flag is clear, and all three undervoltage states are clear.
- R9: While `sampleValid` is low, no comparison state changes, whatever the feedback inputs do.
- R10: A synchronous reset (`rst` high at a clock edge) drives both good flags low and clears the overvoltage flag at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | All feedback codes are valid this cycle |
| coreRef | input | 10 | Core reference code |
| coreFb | input | 10 | Core feedback code |
| busFb | input | 10 | Bus-termination rail feedback code |
| gfxFb | input | 10 | First scaled auxiliary rail feedback code |
| chipFb | input | 10 | Second scaled auxiliary rail feedback code |
| ssLevel | input | 10 | Core soft-start level code |
| pwmPulse | input | 1 | One-cycle PWM pulse event |
| busGood | output | 1 | Delayed bus-rail good flag |
| sysGood | output | 1 | System power-good flag |
| overVolt | output | 1 | Core overvoltage flag |

## Verification
The assertions assume that the reference code stays the same between the samples that use it. Under that assumption the overvoltage threshold never falls below the upper window trip. This is what lets the assertions tie the overvoltage flag to the upper-limit state and keep the two window flags exclusive. The assertions also assume that `rst` is high for the first clock edge. The directed stimulus holds one reference for each run of samples and changes it only together with a fresh core sample. The random phase draws a new reference on every sample, but always alongside a new core code. The bench starts with reset high from time zero.

// File: rtl/railmon_pkg.sv
package railmon_pkg;

  // Strobes issued by the control to the datapath registers.
  typedef struct packed {
    logic capture;
    logic clear;
  } strobe_t;

  // Registered health states produced by the datapath.
  typedef struct packed {
    logic       coreHigh;
    logic       coreLow;
    logic       busUv;
    logic [1:0] linUv;
    logic       ssAbove;
    logic       overVolt;
  } status_t;

  typedef enum logic [1:0] {
    BG_WAIT  = 2'd0,
    BG_ARMED = 2'd1,
    BG_GOOD  = 2'd2
  } busGoodState_e;

endpackage

// File: rtl/railmon_hyst.sv
module railmon_hyst
  import railmon_pkg::*;
#(
  parameter int W          = 12,
  parameter bit HIGH_SIDE  = 1'b0,
  parameter bit RESET_FLAG = 1'b1
) (
  input  logic         clk,
  input  strobe_t      strobe,
  input  logic [W-1:0] value,
  input  logic [W-1:0] setThr,
  input  logic [W-1:0] releaseThr,
  output logic         flag
);

  logic setHit;
  logic relHit;

  if (HIGH_SIDE) begin : g_high
    assign setHit = value > setThr;
    assign relHit = value < releaseThr;
  end else begin : g_low
    assign setHit = value < setThr;
    assign relHit = value > releaseThr;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      flag <= RESET_FLAG;
    end else if (strobe.capture) begin
      if (setHit) begin
        flag <= 1'b1;
      end else if (relHit) begin
        flag <= 1'b0;
      end
    end
  end

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.capture |=> $stable(flag)) else $error("hyst flag moved without strobe"); // R9

  AST_SET_ON_CROSS: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && setHit) |=> flag) else $error("hyst flag missed crossing"); // R9

endmodule

// File: rtl/railmon_datapath.sv
module railmon_datapath
  import railmon_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int GFX_NOM  = 375,
  parameter int CHIP_NOM = 450,
  parameter int BUS_RISE = 270,
  parameter int BUS_HYST = 12,
  parameter int VALLEY   = 312
) (
  input  logic                   clk,
  input  strobe_t                strobe,
  input  logic [CODE_W-1:0]      coreRef,
  input  logic [CODE_W-1:0]      coreFb,
  input  logic [CODE_W-1:0]      busFb,
  input  logic [1:0][CODE_W-1:0] linFb,
  input  logic [CODE_W-1:0]      ssLevel,
  output status_t                status
);

  localparam int EW = CODE_W + 2;
  localparam logic [EW-1:0] BUS_RISE_C = EW'(BUS_RISE);
  localparam logic [EW-1:0] BUS_FALL_C = EW'(BUS_RISE - BUS_HYST);
  localparam logic [EW-1:0] VALLEY_C   = EW'(VALLEY);

  logic [EW-1:0] refX, coreX, busX, ssX;
  logic [EW-1:0] hiTrip, hiRelease, loTrip, loRelease, ovThr;

  assign refX  = EW'(coreRef);
  assign coreX = EW'(coreFb);
  assign busX  = EW'(busFb);
  assign ssX   = EW'(ssLevel);

  // Reference-relative thresholds, shift-and-add only.
  assign hiTrip    = refX + (refX >> 4) + (refX >> 5);
  assign hiRelease = refX + (refX >> 4) + (refX >> 7);
  assign loTrip    = refX - (refX >> 4) - (refX >> 5);
  assign loRelease = refX - (refX >> 4) - (refX >> 7);
  assign ovThr     = refX + (refX >> 3) + (refX >> 4) + (refX >> 6);

  railmon_hyst #(.W(EW), .HIGH_SIDE(1'b1), .RESET_FLAG(1'b0)) u_coreHigh (
    .clk(clk), .strobe(strobe), .value(coreX),
    .setThr(hiTrip), .releaseThr(hiRelease), .flag(status.coreHigh));

  railmon_hyst #(.W(EW), .HIGH_SIDE(1'b0), .RESET_FLAG(1'b1)) u_coreLow (
    .clk(clk), .strobe(strobe), .value(coreX),
    .setThr(loTrip), .releaseThr(loRelease), .flag(status.coreLow));

  railmon_hyst #(.W(EW), .HIGH_SIDE(1'b0), .RESET_FLAG(1'b1)) u_busUv (
    .clk(clk), .strobe(strobe), .value(busX),
    .setThr(BUS_FALL_C), .releaseThr(BUS_RISE_C), .flag(status.busUv));

  for (genvar g = 0; g < 2; g++) begin : g_lin
    localparam int NOM  = (g == 0) ? GFX_NOM : CHIP_NOM;
    localparam int RISE = NOM - (NOM >> 2);
    localparam int FALL = RISE - (NOM >> 4) - (NOM >> 7);
    railmon_hyst #(.W(EW), .HIGH_SIDE(1'b0), .RESET_FLAG(1'b1)) u_linUv (
      .clk(clk), .strobe(strobe), .value(EW'(linFb[g])),
      .setThr(EW'(FALL)), .releaseThr(EW'(RISE)), .flag(status.linUv[g]));
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      status.ssAbove  <= 1'b0;
      status.overVolt <= 1'b0;
    end else if (strobe.capture) begin
      status.ssAbove  <= ssX >= VALLEY_C;
      status.overVolt <= coreX > ovThr;
    end
  end

  AST_OV_IMPLIES_HIGH: assert property (@(posedge clk) disable iff (strobe.clear)
    status.overVolt |-> status.coreHigh) else $error("overvoltage without high window"); // R7

  AST_WINDOW_EXCLUSIVE: assert property (@(posedge clk) disable iff (strobe.clear)
    !(status.coreHigh && status.coreLow)) else $error("core both high and low"); // R1

endmodule

// File: rtl/railmon_control.sv
module railmon_control
  import railmon_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sampleValid,
  input  logic    pwmPulse,
  input  logic    busUv,
  input  logic    ssAbove,
  output strobe_t strobe,
  output logic    busGood
);

  busGoodState_e state, stateNext;

  assign strobe.clear   = rst;
  assign strobe.capture = sampleValid && !rst;

  always_comb begin
    stateNext = state;
    if (busUv || !ssAbove) begin
      stateNext = BG_WAIT;
    end else begin
      unique case (state)
        BG_WAIT:  stateNext = BG_ARMED;
        BG_ARMED: if (pwmPulse) stateNext = BG_GOOD;
        BG_GOOD:  stateNext = BG_GOOD;
        default:  stateNext = BG_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= BG_WAIT;
    else     state <= stateNext;
  end

  assign busGood = (state == BG_GOOD);

  AST_GOOD_NEEDS_BUS: assert property (@(posedge clk) disable iff (rst)
    busGood |-> $past(!busUv && ssAbove)) else $error("bus good without healthy bus"); // R5

  AST_RISE_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busGood) |-> $past(pwmPulse)) else $error("bus good rose without pulse"); // R6

endmodule

// File: rtl/railGoodMonitor.sv
module railGoodMonitor
  import railmon_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int GFX_NOM  = 375,
  parameter int CHIP_NOM = 450,
  parameter int BUS_RISE = 270,
  parameter int BUS_HYST = 12,
  parameter int VALLEY   = 312
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] coreRef,
  input  logic [CODE_W-1:0] coreFb,
  input  logic [CODE_W-1:0] busFb,
  input  logic [CODE_W-1:0] gfxFb,
  input  logic [CODE_W-1:0] chipFb,
  input  logic [CODE_W-1:0] ssLevel,
  input  logic              pwmPulse,
  output logic              busGood,
  output logic              sysGood,
  output logic              overVolt
);

  strobe_t strobe;
  status_t status;
  logic [1:0][CODE_W-1:0] linFb;

  assign linFb = {chipFb, gfxFb};

  railmon_control u_control (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .pwmPulse(pwmPulse),
    .busUv(status.busUv), .ssAbove(status.ssAbove),
    .strobe(strobe), .busGood(busGood));

  railmon_datapath #(
    .CODE_W(CODE_W), .GFX_NOM(GFX_NOM), .CHIP_NOM(CHIP_NOM),
    .BUS_RISE(BUS_RISE), .BUS_HYST(BUS_HYST), .VALLEY(VALLEY)
  ) u_datapath (
    .clk(clk), .strobe(strobe), .coreRef(coreRef), .coreFb(coreFb),
    .busFb(busFb), .linFb(linFb), .ssLevel(ssLevel), .status(status));

  assign sysGood  = !status.coreHigh && !status.coreLow && !status.busUv && !(|status.linUv);
  assign overVolt = status.overVolt;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busGood && !sysGood && !overVolt)) else $error("flags not cleared by reset"); // R10

endmodule

// File: tb/railGoodMonitor_tb.sv
module railGoodMonitor_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic pwmPulse = 1'b0;
  logic [9:0] coreRef = '0, coreFb = '0, busFb = '0, gfxFb = '0, chipFb = '0, ssLevel = '0;
  logic busGood, sysGood, overVolt;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit chkOn = 1'b0;

  // Behavioural reference state
  int mHigh, mLow, mBusUv, mGfxUv, mChipUv, mSsUp, mOv, mState;

  always #10 clk = ~clk;

  railGoodMonitor u_dut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .coreRef(coreRef),
    .coreFb(coreFb), .busFb(busFb), .gfxFb(gfxFb), .chipFb(chipFb),
    .ssLevel(ssLevel), .pwmPulse(pwmPulse),
    .busGood(busGood), .sysGood(sysGood), .overVolt(overVolt));

  function automatic int linUpdate(int cur, int v, int nom);
    int rise, fall;
    rise = nom - nom / 4;
    fall = rise - nom / 16 - nom / 128;
    if (v < fall) return 1;
    if (v > rise) return 0;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mHigh = 0; mLow = 1; mBusUv = 1; mGfxUv = 1; mChipUv = 1;
      mSsUp = 0; mOv = 0; mState = 0;
    end else begin
      // bus-good sequencer uses the states registered before this edge
      if (mBusUv != 0 || mSsUp == 0) mState = 0;
      else if (mState == 0) mState = 1;
      else if (mState == 1 && pwmPulse) mState = 2;
      if (sampleValid) begin
        int r, c;
        r = coreRef; c = coreFb;
        if (c > r + r / 16 + r / 32) mHigh = 1;
        else if (c < r + r / 16 + r / 128) mHigh = 0;
        if (c < r - r / 16 - r / 32) mLow = 1;
        else if (c > r - r / 16 - r / 128) mLow = 0;
        if (busFb < 258) mBusUv = 1;
        else if (busFb > 270) mBusUv = 0;
        mGfxUv  = linUpdate(mGfxUv, gfxFb, 375);
        mChipUv = linUpdate(mChipUv, chipFb, 450);
        mSsUp = (ssLevel >= 312) ? 1 : 0;
        mOv = (c > r + r / 8 + r / 16 + r / 64) ? 1 : 0;
      end
    end
  end

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (chkOn) begin
      check("R5/R6 busGood model", busGood, mState == 2);
      check("R8 sysGood model", sysGood,
            (mHigh == 0 && mLow == 0 && mBusUv == 0 && mGfxUv == 0 && mChipUv == 0));
      check("R7 overVolt model", overVolt, mOv != 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    pwmPulse = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset busGood", busGood, 1'b0);
    check("R10 reset sysGood", sysGood, 1'b0);
    check("R10 reset overVolt", overVolt, 1'b0);
    rst = 1'b0;
    chkOn = 1'b1;

    coreRef = 300; coreFb = 300; busFb = 300; gfxFb = 375; chipFb = 450;
    ssLevel = 0; sampleValid = 1'b1;
    tick();
    check("R8 all rails healthy", sysGood, 1'b1);
    check("R5 soft-start below valley", busGood, 1'b0);
    pwmPulse = 1'b1; tick(); tick();
    check("R5 pulse ignored while soft-start low", busGood, 1'b0);
    ssLevel = 400; tick(); tick();
    check("R6 armed but no pulse yet", busGood, 1'b0);
    pwmPulse = 1'b1; tick();
    check("R6 rises on pulse", busGood, 1'b1);

    sampleValid = 1'b0; busFb = 100;
    tick(); tick(); tick();
    check("R9 no capture keeps busGood", busGood, 1'b1);
    check("R9 no capture keeps sysGood", sysGood, 1'b1);
    sampleValid = 1'b1; tick();
    check("R4 bus undervoltage drops sysGood", sysGood, 1'b0);
    tick();
    check("R5 bus undervoltage drops busGood", busGood, 1'b0);

    busFb = 262; tick(); check("R4 stays under inside band", sysGood, 1'b0);
    busFb = 271; tick(); check("R4 clears above 270", sysGood, 1'b1);
    busFb = 262; tick(); check("R4 stays clear inside band", sysGood, 1'b1);
    busFb = 257; tick(); check("R4 sets below 258", sysGood, 1'b0);
    busFb = 300; tick(); check("R4 recovered", sysGood, 1'b1);

    gfxFb = 258; tick(); check("R3 gfx at 258 ok", sysGood, 1'b1);
    gfxFb = 256; tick(); check("R3 gfx below 257", sysGood, 1'b0);
    gfxFb = 282; tick(); check("R3 gfx at rise still under", sysGood, 1'b0);
    gfxFb = 283; tick(); check("R3 gfx above rise", sysGood, 1'b1);
    chipFb = 307; tick(); check("R3 chip at fall ok", sysGood, 1'b1);
    chipFb = 306; tick(); check("R3 chip below fall", sysGood, 1'b0);
    chipFb = 338; tick(); check("R3 chip at rise still under", sysGood, 1'b0);
    chipFb = 339; tick(); check("R3 chip above rise", sysGood, 1'b1);

    coreFb = 327; tick(); check("R1 at upper trip", sysGood, 1'b1);
    coreFb = 328; tick(); check("R1 above upper trip", sysGood, 1'b0);
    coreFb = 320; tick(); check("R1 at upper release", sysGood, 1'b0);
    coreFb = 319; tick(); check("R1 below upper release", sysGood, 1'b1);
    coreFb = 273; tick(); check("R2 at lower trip", sysGood, 1'b1);
    coreFb = 272; tick(); check("R2 below lower trip", sysGood, 1'b0);
    coreFb = 280; tick(); check("R2 at lower release", sysGood, 1'b0);
    coreFb = 281; tick(); check("R2 above lower release", sysGood, 1'b1);

    coreFb = 359; tick(); check("R7 at overvoltage limit", overVolt, 1'b0);
    coreFb = 360; tick(); check("R7 above overvoltage limit", overVolt, 1'b1);
    coreFb = 300; tick(); check("R7 overvoltage released", overVolt, 1'b0);
    check("R1 window restored", sysGood, 1'b1);

    pwmPulse = 1'b1; tick();
    check("R6 rises again on pulse", busGood, 1'b1);
    ssLevel = 100; tick(); tick();
    check("R5 soft-start drop clears busGood", busGood, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      int pick;
      pick = $urandom_range(0, 3);
      coreRef = (pick == 0) ? 280 : (pick == 1) ? 300 : (pick == 2) ? 320 : 360;
      coreFb = 10'(coreRef * $urandom_range(85, 125) / 100);
      busFb = 10'($urandom_range(240, 300));
      gfxFb = 10'($urandom_range(240, 400));
      chipFb = 10'($urandom_range(290, 470));
      ssLevel = ($urandom_range(0, 5) == 0) ? 10'($urandom_range(0, 330)) : 10'($urandom_range(300, 1023));
      sampleValid = ($urandom_range(0, 3) != 0);
      pwmPulse = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 400) == 0) rst = 1'b1;
      tick();
      rst = 1'b0;
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule